// File: doc/BRIEF.md
# NIC Stream Destination Port Tagger

This block is a single-stage AXI4-Stream pass-through for a network interface card datapath. It stamps an egress tag on every packet. Each packet carries an 8-bit one-hot source tag in its TUSER sideband, and the block writes a one-hot destination tag next to it on the packet's first beat. The destination comes from a fixed pairing and no table is involved. Even tag bits stand for physical network ports and odd tag bits stand for host queues. Physical port bit 2k is paired with host queue bit 2k+1.

Traffic that enters from a wire is sent up to its paired host queue. Traffic that comes down from a host queue is sent out of its paired wire. The payload, byte enables and end-of-packet marker are never changed. The stage adds one cycle of latency, runs at full throughput and passes backpressure through in both directions.

An AXI-Lite slave sits beside the datapath and holds a small self-test bank. It has two constant identity words, an inverting scratch register, an offset-adding scratch register, and two packet counters, one for each side of the stage.

Top module: `nic_dport_tagger`

## Requirements
- R1: On the first beat of a packet whose source tag (TUSER[SRC_LSB+7:SRC_LSB], default bits 23:16) has exactly one bit set and that bit is even, the destination tag (TUSER[DST_LSB+7:DST_LSB], default bits 31:24) leaves as the source tag shifted up by one bit. Examples: 0x01→0x02 and 0x40→0x80.
- R2: On the first beat of a packet whose source tag has exactly one bit set and that bit is odd, the destination tag leaves as the source tag shifted down by one bit. Examples: 0x02→0x01 and 0x80→0x40.
- R3: On the first beat of a packet, a source tag with zero bits set or with more than one bit set produces a destination tag of 0x00.
- R4: Apart from the destination field of the first beat, every TUSER bit, all of TDATA, all of TKEEP and TLAST leave unchanged. Beats after the first keep their original TUSER. A beat counts as a first beat when it follows reset or follows a beat with TLAST set.
- R5: Every accepted beat appears at the output exactly once and in order, one cycle after it is accepted. While the output is valid and not ready, the output beat holds stable. After reset the output is not valid and the input is ready.
- R6: A read at byte offset 0x0 returns BLOCK_ID and a read at 0x4 returns BLOCK_VER. Writes to these offsets have no effect.
- R7: A read at offset 0x8 returns the bitwise inverse of the stored scratch word. The stored word resets to 0, so the first read returns 0xFFFFFFFF.
- R8: A read at offset 0x14 returns the stored debug word plus DEBUG_ADD, taken modulo 2^32. The stored word resets to 0.
- R9: Offset 0xC counts packets whose TLAST beat completes a handshake at the input. Offset 0x10 counts packets whose TLAST beat completes a handshake at the output. Both are CNT_W bits wide (32 by default), wrap to zero, read back zero-extended, reset to 0 and ignore writes.
- R10: Every write, at any address, gets BRESP = 0 (OKAY). A read from any offset other than the six mapped ones returns 0 with RRESP = 0.
- R11: A write to offset 0x8 or 0x14 updates only the bytes whose WSTRB bit is set. WSTRB bit n covers WDATA[8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | DATA_W | Ingress beat data |
| s_tkeep | input | DATA_W/8 | Ingress byte enables |
| s_tuser | input | USER_W | Ingress sideband metadata |
| s_tlast | input | 1 | Ingress end of packet |
| s_tvalid | input | 1 | Ingress beat valid |
| s_tready | output | 1 | Ingress ready |
| m_tdata | output | DATA_W | Egress beat data |
| m_tkeep | output | DATA_W/8 | Egress byte enables |
| m_tuser | output | USER_W | Egress metadata with destination tag |
| m_tlast | output | 1 | Egress end of packet |
| m_tvalid | output | 1 | Egress beat valid |
| m_tready | input | 1 | Egress ready |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |

## Verification
The bench builds the block with DATA_W = 32, USER_W = 32 and the default tag positions, so a full TUSER word can be compared in one value. CNT_W is set to 4, so both packet counters wrap after only 16 packets and the wrap can be seen within a short run. DEBUG_ADD is set to 0xFFFFFFF0, so a small written value makes the debug readback overflow past 2^32. BLOCK_ID and BLOCK_VER are given distinct non-zero values, so they cannot be confused with each other or with the zero returned for unmapped offsets.

// File: rtl/nic_tag_pkg.sv
package nic_tag_pkg;

    localparam int TAG_W = 8;

    typedef enum logic [2:0] {
        RG_ID   = 3'd0,
        RG_VER  = 3'd1,
        RG_FLIP = 3'd2,
        RG_CIN  = 3'd3,
        RG_COUT = 3'd4,
        RG_DBG  = 3'd5,
        RG_NONE = 3'd7
    } reg_sel_e;

    // Word index (byte offset / 4) to register select
    function automatic reg_sel_e sel_of(input logic [31:0] widx);
        case (widx)
            32'd0:   return RG_ID;
            32'd1:   return RG_VER;
            32'd2:   return RG_FLIP;
            32'd3:   return RG_CIN;
            32'd4:   return RG_COUT;
            32'd5:   return RG_DBG;
            default: return RG_NONE;
        endcase
    endfunction

    // Even tag bits are wire ports, odd bits are host queues
    function automatic logic [TAG_W-1:0] wire_mask();
        logic [TAG_W-1:0] m;
        m = '0;
        for (int i = 0; i < TAG_W; i += 2) m[i] = 1'b1;
        return m;
    endfunction

    // Paired egress tag; zero when the source is not one-hot
    function automatic logic [TAG_W-1:0] steer_tag(input logic [TAG_W-1:0] src);
        int ones;
        ones = 0;
        for (int i = 0; i < TAG_W; i++) ones += int'(src[i]);
        if (ones != 1) return '0;
        if ((src & wire_mask()) != '0) return src << 1;
        return src >> 1;
    endfunction

endpackage

// File: rtl/nic_tag_stage.sv
module nic_tag_stage
    import nic_tag_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int USER_W  = 128,
    parameter int SRC_LSB = 16,
    parameter int DST_LSB = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [DATA_W/8-1:0] s_tkeep,
    input  logic [USER_W-1:0]   s_tuser,
    input  logic                s_tlast,
    input  logic                s_tvalid,
    output logic                s_tready,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic [USER_W-1:0]   m_tuser,
    output logic                m_tlast,
    output logic                m_tvalid,
    input  logic                m_tready
);
    localparam int KEEP_W = DATA_W / 8;

    logic              head_q;
    logic [USER_W-1:0] user_nx;
    logic              take;

    assign s_tready = !m_tvalid || m_tready;
    assign take     = s_tvalid && s_tready;

    always_comb begin
        user_nx = s_tuser;
        if (head_q)
            user_nx[DST_LSB +: TAG_W] = steer_tag(s_tuser[SRC_LSB +: TAG_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_tvalid <= 1'b0;
            head_q   <= 1'b1;
        end else begin
            if (s_tready) m_tvalid <= s_tvalid;
            if (take)     head_q   <= s_tlast;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            m_tdata <= s_tdata;
            m_tkeep <= s_tkeep[KEEP_W-1:0];
            m_tuser <= user_nx;
            m_tlast <= s_tlast;
        end
    end

endmodule

// File: rtl/nic_tag_pktcnt.sv
module nic_tag_pktcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (bump) count <= count + 1'b1;
    end
endmodule

// File: rtl/nic_tag_regs.sv
module nic_tag_regs
    import nic_tag_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] BLOCK_ID  = 32'h0000_7A60,
    parameter logic [31:0] BLOCK_VER = 32'h0001_0000,
    parameter logic [31:0] DEBUG_ADD = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [CNT_W-1:0]  cnt_out,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready
);
    localparam int NBYTE = 4;

    logic [31:0] flip_q, dbg_q, rd_val;
    logic        wr_go, rd_go;
    reg_sel_e    wsel, rsel;

    assign wr_go   = awvalid && wvalid && !bvalid;
    assign awready = wr_go;
    assign wready  = wr_go;
    assign rd_go   = arvalid && !rvalid;
    assign arready = !rvalid;
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;

    assign wsel = sel_of(32'(awaddr >> 2));
    assign rsel = sel_of(32'(araddr >> 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            flip_q <= '0;
            dbg_q  <= '0;
            bvalid <= 1'b0;
        end else begin
            if (wr_go) begin
                bvalid <= 1'b1;
                for (int b = 0; b < NBYTE; b++) begin
                    if (wstrb[b]) begin
                        if (wsel == RG_FLIP) flip_q[8*b +: 8] <= wdata[8*b +: 8];
                        if (wsel == RG_DBG)  dbg_q[8*b +: 8]  <= wdata[8*b +: 8];
                    end
                end
            end else if (bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rsel)
            RG_ID:   rd_val = BLOCK_ID;
            RG_VER:  rd_val = BLOCK_VER;
            RG_FLIP: rd_val = ~flip_q;
            RG_CIN:  rd_val = 32'(cnt_in);
            RG_COUT: rd_val = 32'(cnt_out);
            RG_DBG:  rd_val = dbg_q + DEBUG_ADD;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_val;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/nic_dport_tagger.sv
module nic_dport_tagger #(
    parameter int          DATA_W    = 64,
    parameter int          USER_W    = 128,
    parameter int          SRC_LSB   = 16,
    parameter int          DST_LSB   = 24,
    parameter int          ADDR_W    = 12,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] BLOCK_ID  = 32'h0000_7A60,
    parameter logic [31:0] BLOCK_VER = 32'h0001_0000,
    parameter logic [31:0] DEBUG_ADD = 32'h0000_0100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [DATA_W/8-1:0] s_tkeep,
    input  logic [USER_W-1:0]   s_tuser,
    input  logic                s_tlast,
    input  logic                s_tvalid,
    output logic                s_tready,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic [USER_W-1:0]   m_tuser,
    output logic                m_tlast,
    output logic                m_tvalid,
    input  logic                m_tready,
    input  logic [ADDR_W-1:0]   s_axil_awaddr,
    input  logic                s_axil_awvalid,
    output logic                s_axil_awready,
    input  logic [31:0]         s_axil_wdata,
    input  logic [3:0]          s_axil_wstrb,
    input  logic                s_axil_wvalid,
    output logic                s_axil_wready,
    output logic [1:0]          s_axil_bresp,
    output logic                s_axil_bvalid,
    input  logic                s_axil_bready,
    input  logic [ADDR_W-1:0]   s_axil_araddr,
    input  logic                s_axil_arvalid,
    output logic                s_axil_arready,
    output logic [31:0]         s_axil_rdata,
    output logic [1:0]          s_axil_rresp,
    output logic                s_axil_rvalid,
    input  logic                s_axil_rready
);
    logic [CNT_W-1:0] in_cnt, out_cnt;
    logic             in_end, out_end;

    assign in_end  = s_tvalid && s_tready && s_tlast;
    assign out_end = m_tvalid && m_tready && m_tlast;

    nic_tag_stage #(
        .DATA_W(DATA_W), .USER_W(USER_W), .SRC_LSB(SRC_LSB), .DST_LSB(DST_LSB)
    ) stage_i (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser),
        .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser),
        .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    nic_tag_pktcnt #(.CNT_W(CNT_W)) cnt_in_i (
        .clk(clk), .rst(rst), .bump(in_end), .count(in_cnt)
    );

    nic_tag_pktcnt #(.CNT_W(CNT_W)) cnt_out_i (
        .clk(clk), .rst(rst), .bump(out_end), .count(out_cnt)
    );

    nic_tag_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLOCK_ID(BLOCK_ID),
        .BLOCK_VER(BLOCK_VER), .DEBUG_ADD(DEBUG_ADD)
    ) regs_i (
        .clk(clk), .rst(rst), .cnt_in(in_cnt), .cnt_out(out_cnt),
        .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
        .wdata(s_axil_wdata), .wstrb(s_axil_wstrb), .wvalid(s_axil_wvalid),
        .wready(s_axil_wready), .bresp(s_axil_bresp), .bvalid(s_axil_bvalid),
        .bready(s_axil_bready), .araddr(s_axil_araddr), .arvalid(s_axil_arvalid),
        .arready(s_axil_arready), .rdata(s_axil_rdata), .rresp(s_axil_rresp),
        .rvalid(s_axil_rvalid), .rready(s_axil_rready)
    );

endmodule

// File: rtl/nic_dport_tagger_chk.sv
module nic_dport_tagger_chk #(
    parameter int DATA_W  = 64,
    parameter int USER_W  = 128,
    parameter int DST_LSB = 24,
    parameter int CNT_W   = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                s_tvalid,
    input logic                s_tready,
    input logic                s_tlast,
    input logic [DATA_W-1:0]   m_tdata,
    input logic [DATA_W/8-1:0] m_tkeep,
    input logic [USER_W-1:0]   m_tuser,
    input logic                m_tlast,
    input logic                m_tvalid,
    input logic                m_tready,
    input logic [CNT_W-1:0]    in_cnt,
    input logic [CNT_W-1:0]    out_cnt,
    input logic                bvalid,
    input logic                bready,
    input logic                rvalid,
    input logic                rready,
    input logic [31:0]         rdata
);
    logic out_head_q;

    always_ff @(posedge clk) begin
        if (rst)                     out_head_q <= 1'b1;
        else if (m_tvalid && m_tready) out_head_q <= m_tlast;
    end

    // R5: stalled output beat holds
    a_r5_hold_stall: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                  && $stable(m_tuser) && $stable(m_tlast));

    // R5: an accepted beat is presented on the next cycle
    a_r5_no_drop: assert property (@(posedge clk) disable iff (rst)
        s_tvalid && s_tready |=> m_tvalid);

    // R1/R2/R3: first-beat destination is one-hot or zero
    a_r3_dst_onehot0: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && out_head_q |-> $onehot0(m_tuser[DST_LSB +: 8]));

    // R9: counters advance by one on each packet end
    a_r9_in_count: assert property (@(posedge clk) disable iff (rst)
        s_tvalid && s_tready && s_tlast |=> in_cnt == CNT_W'($past(in_cnt) + 1'b1));

    a_r9_out_count: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && m_tready && m_tlast |=> out_cnt == CNT_W'($past(out_cnt) + 1'b1));

    // R10: responses wait for their ready
    a_r10_b_hold: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

    a_r10_r_hold: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));

endmodule

bind nic_dport_tagger nic_dport_tagger_chk #(
    .DATA_W(DATA_W), .USER_W(USER_W), .DST_LSB(DST_LSB), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst(rst),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser),
    .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .in_cnt(in_cnt), .out_cnt(out_cnt),
    .bvalid(s_axil_bvalid), .bready(s_axil_bready),
    .rvalid(s_axil_rvalid), .rready(s_axil_rready), .rdata(s_axil_rdata)
);

// File: tb/nic_dport_tagger_tb_top.sv
module nic_dport_tagger_tb_top;
    localparam int          DW   = 32;
    localparam int          UW   = 32;
    localparam int          KW   = DW / 8;
    localparam int          CW   = 4;
    localparam logic [31:0] B_ID  = 32'h0000_A51C;
    localparam logic [31:0] B_VER = 32'h0001_0203;
    localparam logic [31:0] D_ADD = 32'hFFFF_FFF0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [DW-1:0] s_tdata = '0;
    logic [KW-1:0] s_tkeep = '0;
    logic [UW-1:0] s_tuser = '0;
    logic s_tlast = 1'b0, s_tvalid = 1'b0, s_tready;
    logic [DW-1:0] m_tdata;
    logic [KW-1:0] m_tkeep;
    logic [UW-1:0] m_tuser;
    logic m_tlast, m_tvalid;
    logic m_tready = 1'b1;
    logic [11:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [31:0] wdata = '0, rdata;
    logic [3:0]  wstrb = 4'hF;
    logic [1:0]  bresp, rresp;

    nic_dport_tagger #(
        .DATA_W(DW), .USER_W(UW), .CNT_W(CW),
        .BLOCK_ID(B_ID), .BLOCK_VER(B_VER), .DEBUG_ADD(D_ADD)
    ) dut_i (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready),
        .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
        .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
        .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
        .s_axil_bready(1'b1), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
        .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
        .s_axil_rvalid(rvalid), .s_axil_rready(1'b1)
    );

    int total = 0, bad = 0;
    int rdy_mode = 0;          // 0 always ready, 1 random, 2 held low
    int pk_in = 0, pk_out = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural expectation of the egress tag
    function automatic logic [7:0] expect_dst(input logic [7:0] src);
        int idx, n;
        n = 0; idx = 0;
        for (int i = 0; i < 8; i++) if (src[i]) begin n++; idx = i; end
        if (n != 1) return 8'h00;
        if (idx % 2 == 0) return 8'(1 << (idx + 1));
        return 8'(1 << (idx - 1));
    endfunction

    // Reference model queues
    logic [DW-1:0] q_data[$];
    logic [KW-1:0] q_keep[$];
    logic [UW-1:0] q_user[$];
    logic          q_last[$];
    bit  mdl_head = 1'b1;
    bit  was_stall = 1'b0;
    logic [DW+KW+UW:0] held;

    always @(negedge clk) begin
        if (!rst) begin
            if (was_stall) begin
                check("R5 hold", {31'd0, m_tvalid}, 32'd1);
                check("R5 hold", {31'd0, held == {m_tdata, m_tkeep, m_tuser, m_tlast}}, 32'd1);
            end
            was_stall = m_tvalid && !m_tready;
            held = {m_tdata, m_tkeep, m_tuser, m_tlast};
            if (m_tvalid && m_tready) begin
                if (q_data.size() == 0) begin
                    check("R5 spurious beat", 32'd1, 32'd0);
                end else begin
                    check("R4 data", m_tdata, q_data.pop_front());
                    check("R4 keep", 32'(m_tkeep), 32'(q_keep.pop_front()));
                    check("R1 R2 R3 R4 user", m_tuser, q_user.pop_front());
                    check("R4 last", 32'(m_tlast), 32'(q_last.pop_front()));
                end
                if (m_tlast) pk_out++;
            end
            if (s_tvalid && s_tready) begin
                logic [UW-1:0] u;
                u = s_tuser;
                if (mdl_head) u[31:24] = expect_dst(s_tuser[23:16]);
                q_data.push_back(s_tdata);
                q_keep.push_back(s_tkeep);
                q_user.push_back(u);
                q_last.push_back(s_tlast);
                mdl_head = s_tlast;
                if (s_tlast) pk_in++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0: m_tready = 1'b1;
                1: m_tready = 1'($urandom % 2);
                default: m_tready = 1'b0;
            endcase
        end
    end

    task automatic push_beat(logic [DW-1:0] d, logic [KW-1:0] k, logic [UW-1:0] u, logic l);
        s_tdata = d; s_tkeep = k; s_tuser = u; s_tlast = l; s_tvalid = 1'b1;
        @(negedge clk);
        while (!s_tready) @(negedge clk);
        @(posedge clk); #1;
        s_tvalid = 1'b0;
    endtask

    task automatic send_pkt(logic [7:0] src, int beats, bit gaps);
        for (int b = 0; b < beats; b++) begin
            logic [UW-1:0] u;
            u = $urandom;
            u[23:16] = src;
            if (gaps) repeat ($urandom % 3) begin @(posedge clk); #1; end
            push_beat($urandom, KW'($urandom), u, b == beats - 1);
        end
    endtask

    task automatic drain();
        while (q_data.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        araddr = a; arvalid = 1'b1;
        @(negedge clk);
        while (!arready) @(negedge clk);
        @(posedge clk); #1;
        arvalid = 1'b0;
        @(negedge clk);
        while (!rvalid) @(negedge clk);
        d = rdata;
        check("R10 rresp", 32'(rresp), 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        while (!(awready && wready)) @(negedge clk);
        @(posedge clk); #1;
        awvalid = 1'b0; wvalid = 1'b0;
        @(negedge clk);
        while (!bvalid) @(negedge clk);
        check("R10 bresp", 32'(bresp), 32'd0);
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0] tags[11] = '{8'h01, 8'h04, 8'h10, 8'h40, 8'h02, 8'h08,
                                 8'h20, 8'h80, 8'h00, 8'h03, 8'hFF};
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R5 reset m_tvalid", 32'(m_tvalid), 32'd0);
        check("R5 reset s_tready", 32'(s_tready), 32'd1);
        @(posedge clk); #1;

        rd(12'h000, v); check("R6 id", v, B_ID);
        rd(12'h004, v); check("R6 version", v, B_VER);
        rd(12'h008, v); check("R7 flip reset", v, 32'hFFFF_FFFF);
        rd(12'h014, v); check("R8 debug reset", v, D_ADD);
        rd(12'h00C, v); check("R9 in reset", v, 32'd0);
        rd(12'h010, v); check("R9 out reset", v, 32'd0);

        // R1 R2 R3: every tag class, ready held high, single and multi-beat
        foreach (tags[i]) send_pkt(tags[i], 1 + (i % 3), 1'b0);
        drain();
        // R5: random backpressure and input gaps
        rdy_mode = 1;
        foreach (tags[i]) send_pkt(tags[i], 1 + (i % 4), 1'b1);
        drain();
        rdy_mode = 0;
        @(posedge clk); #1;
        rd(12'h00C, v); check("R9 in wrap", v, 32'(pk_in % 16));
        rd(12'h010, v); check("R9 out wrap", v, 32'(pk_out % 16));
        check("R9 packets sent", 32'(pk_in), 32'd22);

        // R9: stall output, input count moves first
        rdy_mode = 2;
        @(posedge clk); #1;
        send_pkt(8'h04, 1, 1'b0);
        rd(12'h00C, v); check("R9 in ahead", v, 32'(pk_in % 16));
        rd(12'h010, v); check("R9 out behind", v, 32'((pk_in - 1) % 16));
        rdy_mode = 0;
        drain();
        rd(12'h010, v); check("R9 out caught up", v, 32'(pk_in % 16));

        // R7 R11
        wr(12'h008, 32'h1234_5678, 4'hF);
        rd(12'h008, v); check("R7 flip", v, 32'hEDCB_A987);
        wr(12'h008, 32'hAAAA_AAFF, 4'b0001);
        rd(12'h008, v); check("R11 flip strobe", v, 32'hEDCB_A900);
        // R8 R11
        wr(12'h014, 32'h0000_0020, 4'hF);
        rd(12'h014, v); check("R8 debug wrap", v, 32'h0000_0010);
        wr(12'h014, 32'h5555_5505, 4'b0100);
        rd(12'h014, v); check("R11 debug strobe", v, 32'h0055_0010);
        // R6 R9: read-only words ignore writes
        wr(12'h000, 32'h0BAD_0BAD, 4'hF);
        rd(12'h000, v); check("R6 id after write", v, B_ID);
        wr(12'h00C, 32'h0000_0009, 4'hF);
        rd(12'h00C, v); check("R9 in after write", v, 32'(pk_in % 16));
        // R10: unmapped
        wr(12'h040, 32'hFFFF_FFFF, 4'hF);
        rd(12'h040, v); check("R10 unmapped 0x40", v, 32'd0);
        rd(12'h018, v); check("R10 unmapped 0x18", v, 32'd0);
        rd(12'hFFC, v); check("R10 unmapped 0xFFC", v, 32'd0);
        rd(12'h008, v); check("R10 flip untouched", v, 32'hEDCB_A900);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule